// File: doc/BRIEF.md
# Indirect Register Window Interrupt Controller

This block is the register front end of a multi-pin interrupt redirection unit. A host bus reaches it through two byte offsets. One holds an 8-bit select register. The other is a 32-bit data window, and the select value decides what the window shows. The window can show the identification register, the version register, or one 32-bit half of the 64-bit redirection entry of any pin. The block holds the redirection table. It decides which entry fields software may change, and it pulses a strobe whenever a write flips a pin's mask bit.

The delivery logic sits next to this block and is out of scope here. It uses two side ports. A status port sets the remote-IRR and delivery-status bits of one entry, and a lookup port returns any entry at once. Bus accesses are single-cycle strobes. Writes take effect at the clock edge, and read data is combinational while the read strobe is high.

Top module: `irw_ctrl`

## Requirements
- R1: A write at offset 0x00 stores bits 7:0 of the data in the select register. A read at offset 0x00 returns the select value in bits 7:0 and zero above it.
- R2: With select 0x01, the window reads (pin count − 1) in bits 23:16 and the version value in bits 7:0, which is 0x00170011 by default. Window writes with this select change nothing.
- R3: With select 0x00, the window reads a 4-bit ID in bits 27:24, and a window write updates only that ID. Select 0x02 reads the same ID, and window writes with select 0x02 are ignored.
- R4: For select 0x10 and up, the entry index is (select − 0x10) >> 1. An odd select maps to entry bits 63:32 and an even select to bits 31:0. A write to one half leaves the other half unchanged.
- R5: Select 0x03–0x0F, or an entry index at or above the pin count, reads as 0xFFFFFFFF. A window write with such a select changes no entry and raises no mask strobe, even when the index truncated to pin width would name a real pin.
- R6: Entry layout: vector 7:0, delivery status bit 12, remote-IRR bit 14, trigger bit 15 (1 = level, 0 = edge), mask bit 16, destination 63:56. Window writes never change bits 12 or 14, except as R7 says.
- R7: After any window write to an entry whose resulting trigger bit is 0 (edge), its remote-IRR bit reads 0.
- R8: After reset, every entry is 0x0000_0000_0001_0000 (masked), the select register and ID are 0, and no mask strobe is active.
- R9: Reads at any offset other than 0x00 and 0x10 return 0, and writes there are ignored. The read data is 0 while the read strobe is low.
- R10: A status-port update writes bits 14 and 12 of the named entry at the next clock edge. If a window write hits the same entry in the same cycle, the window write wins and those bits keep their old values.
- R11: The lookup port returns the full 64-bit entry for a pin index below the pin count, and all ones otherwise.
- R12: When a window write changes an entry's mask bit, the strobe is high for exactly the cycle after the write edge and carries the pin index and the new mask value. A write that leaves the mask unchanged raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| st_we | input | 1 | Status update strobe from delivery logic |
| st_pin | input | 5 | Entry targeted by the status update |
| st_rirr | input | 1 | New remote-IRR value |
| st_dstat | input | 1 | New delivery-status value |
| look_pin | input | 5 | Lookup pin index |
| look_entry | output | 64 | Entry of the lookup pin |
| mask_chg_vld | output | 1 | Mask-change strobe |
| mask_chg_pin | output | 5 | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |

## Verification
Software cannot set remote-IRR or delivery status at all, so the hardest cases to reach from the bus are the protection of those bits and the edge-mode clearing. The bench first sets both bits through the status port. It then writes the entry through the window in level mode, then switches it to edge mode. It also re-arms remote-IRR on an edge entry and writes only the upper half, which shows that the clearing follows every write and not just a change of trigger mode. One case fires a status update and a window write at the same entry in the same cycle. Another uses a select whose index wraps to pin 0 when truncated, to show that out-of-range writes are dropped and do not alias a real pin.

// File: rtl/irw_pkg.sv
// Shared constants and types for the indirect register window controller.
// Assumes 8-bit select values and a 64-bit redirection entry.
package irw_pkg;
    localparam int SEL_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ENTRY_W = 64;

    // Bit positions inside an entry that the logic depends on
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    // Reset value of every entry: only the mask bit set
    localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    // Classification of the current select value
    typedef enum logic [2:0] {
        SK_ID  = 3'd0,
        SK_VER = 3'd1,
        SK_ARB = 3'd2,
        SK_ENT = 3'd3,
        SK_BAD = 3'd4
    } sel_kind_e;
endpackage

// File: rtl/irw_sel_decode.sv
// Decodes the select register into a register class, an entry index and
// a half flag. Assumes the pin count fits in a 7-bit index.
module irw_sel_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic [SEL_W-1:0] sel,
    output sel_kind_e        kind,
    output logic [PIN_W-1:0] idx,
    output logic             hi
);
    logic [SEL_W-2:0] idx_full;

    // Classify the select value and derive the entry index
    always_comb begin
        idx_full = (SEL_W-1)'((sel - 8'h10) >> 1);
        idx      = idx_full[PIN_W-1:0];
        hi       = sel[0];
        if (sel == 8'h00)
            kind = SK_ID;
        else if (sel == 8'h01)
            kind = SK_VER;
        else if (sel == 8'h02)
            kind = SK_ARB;
        else if (sel >= 8'h10 && int'(idx_full) < NUM_PINS)
            kind = SK_ENT;
        else
            kind = SK_BAD;
    end
endmodule

// File: rtl/irw_entry.sv
// One redirection entry. Merges half writes, protects the status bits,
// clears remote-IRR on edge mode and takes status updates. A bus write
// wins over a status update in the same cycle.
module irw_entry
    import irw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               st_we,
    input  logic               st_rirr,
    input  logic               st_dstat,
    output logic [ENTRY_W-1:0] q,
    output logic               mask_flip
);
    logic [ENTRY_W-1:0] nxt;

    // Next entry value from bus write or status update
    always_comb begin
        nxt = q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) nxt[31:0]  = wdata;
            if (wr_hi) nxt[63:32] = wdata;
            nxt[B_DSTAT] = q[B_DSTAT];
            nxt[B_RIRR]  = q[B_RIRR] & nxt[B_TRIG];
        end else if (st_we) begin
            nxt[B_DSTAT] = st_dstat;
            nxt[B_RIRR]  = st_rirr;
        end
    end

    // Mask bit toggles only through a low-half write
    assign mask_flip = wr_lo && (wdata[B_MASK] != q[B_MASK]);

    // Entry storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= ENTRY_RST;
        else
            q <= nxt;
    end
endmodule

// File: rtl/irw_rdmux.sv
// Read-data multiplexer for the bus and the lookup port. Purely
// combinational; assumes the table is presented as a packed array.
module irw_rdmux
    import irw_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          PIN_W    = $clog2(NUM_PINS),
    parameter logic [7:0]  VER_ID   = 8'h11,
    parameter logic [7:0]  SEL_OFF  = 8'h00,
    parameter logic [7:0]  WIN_OFF  = 8'h10
) (
    input  logic                              bus_rd,
    input  logic [7:0]                        bus_addr,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [3:0]                        id,
    input  sel_kind_e                         kind,
    input  logic [PIN_W-1:0]                  idx,
    input  logic                              hi,
    input  logic [NUM_PINS-1:0][ENTRY_W-1:0]  tbl,
    input  logic [PIN_W-1:0]                  look_pin,
    output logic [DATA_W-1:0]                 rdata,
    output logic [ENTRY_W-1:0]                look_entry
);
    localparam logic [7:0] PINS_M1 = 8'(NUM_PINS - 1);

    // Bus read data selection
    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            if (bus_addr == SEL_OFF) begin
                rdata = {24'h0, sel};
            end else if (bus_addr == WIN_OFF) begin
                case (kind)
                    SK_ID, SK_ARB: rdata = {4'h0, id, 24'h0};
                    SK_VER:        rdata = {8'h0, PINS_M1, 8'h0, VER_ID};
                    SK_ENT:        rdata = hi ? tbl[idx][63:32] : tbl[idx][31:0];
                    default:       rdata = '1;
                endcase
            end
        end
    end

    // Lookup port for the delivery logic
    always_comb begin
        if (int'(look_pin) < NUM_PINS)
            look_entry = tbl[look_pin];
        else
            look_entry = '1;
    end
endmodule

// File: rtl/irw_ctrl.sv
// Register front end of an interrupt redirection unit: select register,
// data window, identification and version registers, redirection table
// and mask-change strobe. Assumes single-cycle bus strobes.
module irw_ctrl
    import irw_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VER_ID   = 8'h11,
    parameter logic [7:0]  SEL_OFF  = 8'h00,
    parameter logic [7:0]  WIN_OFF  = 8'h10,
    localparam int         PIN_W    = $clog2(NUM_PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               st_we,
    input  logic [PIN_W-1:0]   st_pin,
    input  logic               st_rirr,
    input  logic               st_dstat,
    input  logic [PIN_W-1:0]   look_pin,
    output logic [63:0]        look_entry,
    output logic               mask_chg_vld,
    output logic [PIN_W-1:0]   mask_chg_pin,
    output logic               mask_chg_val
);
    logic [SEL_W-1:0]                 sel_q;
    logic [3:0]                       id_q;
    sel_kind_e                        kind;
    logic [PIN_W-1:0]                 idx;
    logic                             hi;
    logic                             win_wr;
    logic                             ent_wr;
    logic [NUM_PINS-1:0][ENTRY_W-1:0] tbl;
    logic [NUM_PINS-1:0]              flip;

    assign win_wr = bus_wr && (bus_addr == WIN_OFF);
    assign ent_wr = win_wr && (kind == SK_ENT);

    irw_sel_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
        .sel  (sel_q),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    // One entry instance per pin
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        logic hit;
        assign hit = ent_wr && (idx == PIN_W'(i));
        irw_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit && !hi),
            .wr_hi     (hit && hi),
            .wdata     (bus_wdata),
            .st_we     (st_we && (st_pin == PIN_W'(i))),
            .st_rirr   (st_rirr),
            .st_dstat  (st_dstat),
            .q         (tbl[i]),
            .mask_flip (flip[i])
        );
    end

    // Select register: low byte of writes to the select offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && bus_addr == SEL_OFF)
            sel_q <= bus_wdata[SEL_W-1:0];
    end

    // Identification register: bits 27:24 of a window write at select 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_wr && kind == SK_ID)
            id_q <= bus_wdata[27:24];
    end

    // Mask-change strobe, valid the cycle after the write edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_chg_vld <= 1'b0;
            mask_chg_pin <= '0;
            mask_chg_val <= 1'b0;
        end else begin
            mask_chg_vld <= |flip;
            if (|flip) begin
                mask_chg_pin <= idx;
                mask_chg_val <= bus_wdata[B_MASK];
            end
        end
    end

    irw_rdmux #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W),
        .VER_ID   (VER_ID),
        .SEL_OFF  (SEL_OFF),
        .WIN_OFF  (WIN_OFF)
    ) u_rd (
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .sel        (sel_q),
        .id         (id_q),
        .kind       (kind),
        .idx        (idx),
        .hi         (hi),
        .tbl        (tbl),
        .look_pin   (look_pin),
        .rdata      (bus_rdata),
        .look_entry (look_entry)
    );
endmodule

// File: rtl/irw_ctrl_chk.sv
// Property checker for irw_ctrl, attached with bind below.
module irw_ctrl_chk #(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  SEL_OFF  = 8'h00,
    parameter logic [7:0]  WIN_OFF  = 8'h10,
    parameter int          PIN_W    = $clog2(NUM_PINS)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [7:0]                   bus_addr,
    input logic [31:0]                  bus_wdata,
    input logic [31:0]                  bus_rdata,
    input logic [7:0]                   sel_q,
    input logic [3:0]                   id_q,
    input logic [NUM_PINS-1:0][63:0]    tbl,
    input logic                         ent_wr,
    input logic [PIN_W-1:0]             wr_idx,
    input logic                         mask_chg_vld,
    input logic [PIN_W-1:0]             mask_chg_pin,
    input logic                         mask_chg_val
);
    AST_SEL_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_OFF) |=> (sel_q == $past(bus_wdata[7:0]))); // R1

    AST_ID_ONLY_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == WIN_OFF && sel_q != 8'h00) |=> $stable(id_q)); // R3

    AST_DSTAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr |=> (tbl[$past(wr_idx)][12] == $past(tbl[wr_idx][12]))); // R6

    AST_RIRR_KEPT_OR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr |=> (tbl[$past(wr_idx)][14] ==
                    ($past(tbl[wr_idx][14]) && tbl[$past(wr_idx)][15]))); // R7

    AST_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || (bus_addr != SEL_OFF && bus_addr != WIN_OFF)) |-> (bus_rdata == 32'h0)); // R9

    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_vld |-> $past(ent_wr)); // R12

    AST_STROBE_MATCHES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_vld |-> (tbl[mask_chg_pin][16] == mask_chg_val)); // R12
endmodule

bind irw_ctrl irw_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .SEL_OFF  (SEL_OFF),
    .WIN_OFF  (WIN_OFF),
    .PIN_W    (PIN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .sel_q        (sel_q),
    .id_q         (id_q),
    .tbl          (tbl),
    .ent_wr       (ent_wr),
    .wr_idx       (idx),
    .mask_chg_vld (mask_chg_vld),
    .mask_chg_pin (mask_chg_pin),
    .mask_chg_val (mask_chg_val)
);

// File: tb/irw_ctrl_tb.sv
// Directed bench for irw_ctrl: one task per scenario.
module irw_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        st_we = 1'b0;
    logic [4:0]  st_pin = '0;
    logic        st_rirr = 1'b0;
    logic        st_dstat = 1'b0;
    logic [4:0]  look_pin = '0;
    logic [63:0] look_entry;
    logic        mask_chg_vld;
    logic [4:0]  mask_chg_pin;
    logic        mask_chg_val;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] SEL = 8'h00;
    localparam logic [7:0] WIN = 8'h10;

    always #2 clk = ~clk;

    irw_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .st_we (st_we), .st_pin (st_pin), .st_rirr (st_rirr), .st_dstat (st_dstat),
        .look_pin (look_pin), .look_entry (look_entry),
        .mask_chg_vld (mask_chg_vld), .mask_chg_pin (mask_chg_pin),
        .mask_chg_val (mask_chg_val)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        wr(SEL, {24'h0, s});
        rd(WIN, d);
    endtask

    task automatic win_write(input logic [7:0] s, input logic [31:0] d);
        wr(SEL, {24'h0, s});
        wr(WIN, d);
    endtask

    task automatic status(input logic [4:0] p, input logic ri, input logic ds);
        @(negedge clk);
        st_we = 1'b1; st_pin = p; st_rirr = ri; st_dstat = ds;
        @(negedge clk);
        st_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R8 no strobe", 64'(mask_chg_vld), 64'h0);
        check("R9 idle rdata", 64'(bus_rdata), 64'h0);
        rd(SEL, v);      check("R8 select", 64'(v), 64'h0);
        rd(WIN, v);      check("R8 id", 64'(v), 64'h0);
        win_read(8'h10, v); check("R8 entry0 lo", 64'(v), 64'h0001_0000);
        win_read(8'h11, v); check("R8 entry0 hi", 64'(v), 64'h0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        wr(SEL, 32'hDEAD_BE5A);
        rd(SEL, v); check("R1 low byte", 64'(v), 64'h5A);
    endtask

    task automatic t_version();
        logic [31:0] v;
        win_read(8'h01, v); check("R2 version", 64'(v), 64'h0017_0011);
        wr(WIN, 32'hFFFF_FFFF);
        rd(WIN, v);      check("R2 write ignored", 64'(v), 64'h0017_0011);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        win_write(8'h00, 32'h5A3C_0000);
        rd(WIN, v);      check("R3 id field", 64'(v), 64'h0A00_0000);
        win_read(8'h02, v); check("R3 arb mirror", 64'(v), 64'h0A00_0000);
        wr(WIN, 32'h0300_0000);
        rd(WIN, v);      check("R3 arb write ignored", 64'(v), 64'h0A00_0000);
    endtask

    task automatic t_entry();
        logic [31:0] v;
        win_write(8'h1B, 32'hC300_0000);
        win_write(8'h1A, 32'h0000_A03A);
        check("R12 strobe", 64'({mask_chg_vld, mask_chg_pin, mask_chg_val}), 64'({1'b1, 5'd5, 1'b0}));
        rd(WIN, v);      check("R4 lo half", 64'(v), 64'h0000_A03A);
        win_write(8'h1B, 32'h7E00_0000);
        win_read(8'h1A, v); check("R4 lo untouched", 64'(v), 64'h0000_A03A);
        look_pin = 5'd5; #1;
        check("R11 lookup", look_entry, 64'h7E00_0000_0000_A03A);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        status(5'd5, 1'b1, 1'b1);
        win_read(8'h1A, v); check("R10 status set", 64'(v), 64'h0000_F03A);
        wr(WIN, 32'h0000_A03A);
        rd(WIN, v);      check("R6 bits kept set", 64'(v), 64'h0000_F03A);
        win_write(8'h1C, 32'h0001_D000);
        check("R12 no strobe", 64'(mask_chg_vld), 64'h0);
        rd(WIN, v);      check("R6 bits kept clear", 64'(v), 64'h0001_8000);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        win_write(8'h1B, 32'h1100_0000);
        win_read(8'h1A, v); check("R6 level hi write", 64'(v), 64'h0000_F03A);
        wr(WIN, 32'h0000_203A);
        rd(WIN, v);      check("R7 edge clears", 64'(v), 64'h0000_303A);
        status(5'd5, 1'b1, 1'b1);
        rd(WIN, v);      check("R10 status on edge", 64'(v), 64'h0000_703A);
        win_write(8'h1B, 32'h2200_0000);
        win_read(8'h1A, v); check("R7 hi write clears", 64'(v), 64'h0000_303A);
    endtask

    task automatic t_range();
        logic [31:0] v;
        win_write(8'h3E, 32'h0000_0041);
        check("R5 last pin strobe", 64'({mask_chg_vld, mask_chg_pin, mask_chg_val}), 64'({1'b1, 5'd23, 1'b0}));
        rd(WIN, v);      check("R5 last pin", 64'(v), 64'h41);
        win_read(8'h40, v); check("R5 index 24", 64'(v), 64'hFFFF_FFFF);
        win_read(8'h41, v); check("R5 index 24 hi", 64'(v), 64'hFFFF_FFFF);
        win_read(8'h05, v); check("R5 gap select", 64'(v), 64'hFFFF_FFFF);
        win_write(8'h50, 32'h0000_0000);
        check("R5 no strobe", 64'(mask_chg_vld), 64'h0);
        win_read(8'h10, v); check("R5 no alias", 64'(v), 64'h0001_0000);
        look_pin = 5'd24; #1;
        check("R11 lookup range", look_entry, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        rd(8'h04, v);    check("R9 offset 04", 64'(v), 64'h0);
        rd(8'h20, v);    check("R9 offset 20", 64'(v), 64'h0);
        wr(8'h14, 32'h0000_00FF);
        rd(SEL, v);      check("R9 write ignored", 64'(v), 64'h10);
    endtask

    task automatic t_mask();
        wr(SEL, 32'h3E);
        wr(WIN, 32'h0000_0041);
        check("R12 same mask", 64'(mask_chg_vld), 64'h0);
        wr(WIN, 32'h0001_0041);
        check("R12 mask set", 64'({mask_chg_vld, mask_chg_pin, mask_chg_val}), 64'({1'b1, 5'd23, 1'b1}));
        @(negedge clk);
        check("R12 one cycle", 64'(mask_chg_vld), 64'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(SEL, 32'h1E);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = WIN; bus_wdata = 32'h0000_8000;
        st_we = 1'b1; st_pin = 5'd7; st_rirr = 1'b1; st_dstat = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; st_we = 1'b0;
        rd(WIN, v);      check("R10 write wins", 64'(v), 64'h0000_8000);
        status(5'd7, 1'b1, 1'b1);
        rd(WIN, v);      check("R10 status after", 64'(v), 64'h0000_D000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_select();
        t_version();
        t_ident();
        t_entry();
        t_readonly();
        t_edge();
        t_range();
        t_offsets();
        t_mask();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule